// File: doc/BRIEF.md
# MCU Clock Enable Generator

This block produces the clock enables for a small microcontroller. It runs on one fast reference clock. Each oscillator source reaches it as a one-cycle tick input: a main crystal, a sub crystal, a low-speed on-chip oscillator and a high-speed on-chip oscillator. The block turns these ticks into one-cycle enable pulses. Downstream logic uses the pulses in place of gated clocks.

One of three sources becomes the system tick. A counter divides the system tick to give the CPU enable. A free-running prescaler divides it to give five peripheral taps. A separate divider, with a ratio from 2 to 9, runs from the high-speed oscillator. The block also passes the raw on-chip oscillator ticks through as enables. Four control groups, each with a write strobe, set the behaviour. Two further inputs drive the power modes: a wait-mode level that can stall the peripheral taps, and a stop-entry pulse that forces the CPU divider to divide by 8.

Top module: `mcu_clkgen`

## Requirements
- R1: During reset every output is low. After reset the system source is the low-speed oscillator and the CPU ratio is 1, so each `ls_tick` gives one `cpu_en` pulse, and `main_tick` and `sub_tick` give none.
- R2: `sc_src` selects the system source: 00 is the main crystal, 01 is the sub crystal, and 10 or 11 is the low-speed oscillator. A new selection takes effect at the next CPU terminal count.
- R3: When the divide-by-8 bit `sc_div8` is 1, the CPU ratio is 8. When it is 0, `cd_cpu` codes 00, 01, 10 and 11 give ratios 1, 2, 4 and 16.
- R4: A CPU ratio change is applied only at the next terminal count of the running period, so the period in progress always completes at its old length.
- R5: Every divided or passed-through enable is registered. It goes high in the reference cycle after the tick that causes it and lasts exactly one cycle.
- R6: `f1_en`, `f2_en`, `f4_en`, `f8_en` and `f32_en` pulse on every 1st, 2nd, 4th, 8th and 32nd system tick, counted from the last prescaler clear. Each pulse of a coarser tap coincides with a pulse of every finer tap.
- R7: While `wait_mode` is 1 and the stored wait-stop bit `sc_wstop` is 1, all five taps stay low and the prescaler is cleared. When `sc_wstop` is 0, the taps keep running in wait mode.
- R8: `oco_en`, `hs_en`, `hsdiv_en` and `ls_en` are not affected by wait mode.
- R9: A `stop_entry` pulse with `stop_nochg` at 0 sets the stored divide-by-8 bit. This overrides a write of 0 in the same cycle. With `stop_nochg` at 1 the pulse has no effect.
- R10: `hsdiv_en` divides `hs_tick` by `hf_code`+2, so code 000 gives 2 and code 111 gives 9. It pulses only while the stored `hf_on` is 1. While off, its counter is cleared and the ratio is reloaded. While on, a new ratio takes effect at the terminal count.
- R11: `hs_en` follows `hs_tick` while the stored `hf_on` is 1 and stays low otherwise.
- R12: `ls_en` follows `ls_tick` while the stored `cd_lo_off` is 0. `oco_en` always follows `ls_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_tick | input | 1 | Main crystal tick |
| sub_tick | input | 1 | Sub crystal tick |
| ls_tick | input | 1 | Low-speed on-chip oscillator tick |
| hs_tick | input | 1 | High-speed on-chip oscillator tick |
| sc_we | input | 1 | Write strobe for the system control group |
| sc_src | input | 2 | System source select |
| sc_div8 | input | 1 | CPU divide-by-8 bit |
| sc_wstop | input | 1 | Stop peripheral taps in wait mode |
| cd_we | input | 1 | Write strobe for the divider control group |
| cd_cpu | input | 2 | CPU ratio code |
| cd_lo_off | input | 1 | Low-speed oscillator output off |
| hf_we | input | 1 | Write strobe for the high-speed divider group |
| hf_on | input | 1 | High-speed oscillator enable |
| hf_code | input | 3 | High-speed divider code (ratio = code+2) |
| stop_nochg | input | 1 | 1 = stop entry leaves the divider bits alone |
| stop_entry | input | 1 | One-cycle stop-mode entry event |
| wait_mode | input | 1 | Wait-mode level |
| cpu_en | output | 1 | CPU clock enable |
| f1_en | output | 1 | Peripheral tap, divide by 1 |
| f2_en | output | 1 | Peripheral tap, divide by 2 |
| f4_en | output | 1 | Peripheral tap, divide by 4 |
| f8_en | output | 1 | Peripheral tap, divide by 8 |
| f32_en | output | 1 | Peripheral tap, divide by 32 |
| oco_en | output | 1 | On-chip oscillator enable |
| hs_en | output | 1 | High-speed oscillator enable |
| hsdiv_en | output | 1 | Divided high-speed oscillator enable |
| ls_en | output | 1 | Low-speed oscillator enable |

## Verification
The prescaler phase cannot be read from the ports, so the tap counts are only exact once that phase is known. The bench forces the prescaler to zero by raising wait mode with the stop bit set. It then counts 64 ticks and checks both the number of pulses per tap and the position of the first divide-by-32 pulse. For the CPU divider, the bench first lets the running period reach its terminal count, then measures the next full period. It also changes the ratio partway through a divide-by-16 period to show that the old period is not cut short. The stop-entry override is driven in the same cycle as a conflicting register write.

// File: rtl/mcu_clkgen.sv
module mcu_clkgen #(
  parameter int CPU_CW = 4,
  parameter int PRE_W  = 5,
  parameter int HF_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            main_tick,
  input  logic            sub_tick,
  input  logic            ls_tick,
  input  logic            hs_tick,
  input  logic            sc_we,
  input  logic [1:0]      sc_src,
  input  logic            sc_div8,
  input  logic            sc_wstop,
  input  logic            cd_we,
  input  logic [1:0]      cd_cpu,
  input  logic            cd_lo_off,
  input  logic            hf_we,
  input  logic            hf_on,
  input  logic [HF_W-1:0] hf_code,
  input  logic            stop_nochg,
  input  logic            stop_entry,
  input  logic            wait_mode,
  output logic            cpu_en,
  output logic            f1_en,
  output logic            f2_en,
  output logic            f4_en,
  output logic            f8_en,
  output logic            f32_en,
  output logic            oco_en,
  output logic            hs_en,
  output logic            hsdiv_en,
  output logic            ls_en
);

  localparam int HS_CW = HF_W + 1;
  localparam logic [1:0] SRC_LS = 2'b10;

  logic [1:0]        src_q, src_act;
  logic              div8_q, wstop_q, lo_off_q, hf_on_q;
  logic [1:0]        cpu_code_q;
  logic [HF_W-1:0]   hf_code_q, hf_code_nx;
  logic [CPU_CW-1:0] cpu_cnt, cpu_lim_q, cpu_lim_nx;
  logic [PRE_W-1:0]  pre_cnt;
  logic [HS_CW-1:0]  hs_cnt, hs_lim_q, hs_lim_nx;
  logic              sys_tick, cpu_term, gate, hs_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= SRC_LS;
      div8_q     <= 1'b0;
      wstop_q    <= 1'b0;
      cpu_code_q <= 2'b00;
      lo_off_q   <= 1'b0;
      hf_on_q    <= 1'b0;
      hf_code_q  <= '0;
    end else begin
      if (sc_we) begin
        src_q   <= sc_src;
        div8_q  <= sc_div8;
        wstop_q <= sc_wstop;
      end
      if (stop_entry && !stop_nochg) div8_q <= 1'b1;
      if (cd_we) begin
        cpu_code_q <= cd_cpu;
        lo_off_q   <= cd_lo_off;
      end
      if (hf_we) begin
        hf_on_q   <= hf_on;
        hf_code_q <= hf_code;
      end
    end
  end

  always_comb begin
    case (src_act)
      2'b00:   sys_tick = main_tick;
      2'b01:   sys_tick = sub_tick;
      default: sys_tick = ls_tick;
    endcase
  end

  always_comb begin
    if (div8_q) cpu_lim_nx = CPU_CW'(7);
    else begin
      case (cpu_code_q)
        2'b00:   cpu_lim_nx = CPU_CW'(0);
        2'b01:   cpu_lim_nx = CPU_CW'(1);
        2'b10:   cpu_lim_nx = CPU_CW'(3);
        default: cpu_lim_nx = CPU_CW'(15);
      endcase
    end
  end

  assign cpu_term = sys_tick && (cpu_cnt == cpu_lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_cnt   <= '0;
      cpu_lim_q <= '0;
      src_act   <= SRC_LS;
      cpu_en    <= 1'b0;
    end else begin
      cpu_en <= cpu_term;
      if (cpu_term) begin
        cpu_cnt   <= '0;
        cpu_lim_q <= cpu_lim_nx;
        src_act   <= src_q;
      end else if (sys_tick) begin
        cpu_cnt <= cpu_cnt + 1'b1;
      end
    end
  end

  assign gate = wait_mode && wstop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      f1_en   <= 1'b0;
      f2_en   <= 1'b0;
      f4_en   <= 1'b0;
      f8_en   <= 1'b0;
      f32_en  <= 1'b0;
    end else begin
      f1_en  <= sys_tick && !gate;
      f2_en  <= sys_tick && !gate && pre_cnt[0];
      f4_en  <= sys_tick && !gate && (&pre_cnt[1:0]);
      f8_en  <= sys_tick && !gate && (&pre_cnt[2:0]);
      f32_en <= sys_tick && !gate && (&pre_cnt);
      if (gate) pre_cnt <= '0;
      else if (sys_tick) pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign hf_code_nx = hf_we ? hf_code : hf_code_q;
  assign hs_lim_nx  = {1'b0, hf_code_nx} + 1'b1;
  assign hs_term    = hf_on_q && hs_tick && (hs_cnt == hs_lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cnt   <= '0;
      hs_lim_q <= HS_CW'(1);
      hsdiv_en <= 1'b0;
      hs_en    <= 1'b0;
      oco_en   <= 1'b0;
      ls_en    <= 1'b0;
    end else begin
      hsdiv_en <= hs_term;
      hs_en    <= hs_tick && hf_on_q;
      oco_en   <= ls_tick;
      ls_en    <= ls_tick && !lo_off_q;
      if (!hf_on_q || hs_term) begin
        hs_cnt   <= '0;
        hs_lim_q <= hs_lim_nx;
      end else if (hs_tick) begin
        hs_cnt <= hs_cnt + 1'b1;
      end
    end
  end

  // R2
  cpu_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |-> $past(sys_tick));

  // R7
  gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gate) |-> !(f1_en || f2_en || f4_en || f8_en || f32_en));

  // R6
  tap_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f32_en |-> (f8_en && f4_en && f2_en && f1_en));

  // R9
  stop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_entry && !stop_nochg) |-> div8_q);

  // R10
  hsdiv_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsdiv_en |-> $past(hf_on_q && hs_tick));

  // R11
  hs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> $past(hs_tick));

endmodule

// File: tb/mcu_clkgen_bench.sv
module mcu_clkgen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic main_tick = 0, sub_tick = 0, ls_tick = 0, hs_tick = 0;
  logic sc_we = 0, sc_div8 = 0, sc_wstop = 0;
  logic [1:0] sc_src = 2'b10;
  logic cd_we = 0, cd_lo_off = 0;
  logic [1:0] cd_cpu = 0;
  logic hf_we = 0, hf_on = 0;
  logic [2:0] hf_code = 0;
  logic stop_nochg = 0, stop_entry = 0, wait_mode = 0;
  logic cpu_en, f1_en, f2_en, f4_en, f8_en, f32_en, oco_en, hs_en, hsdiv_en, ls_en;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  mcu_clkgen u_mcu_clkgen (.*);

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int which);
    @(negedge clk);
    main_tick = (which == 0); sub_tick = (which == 1);
    ls_tick = (which == 2); hs_tick = (which == 3);
    @(negedge clk);
    main_tick = 0; sub_tick = 0; ls_tick = 0; hs_tick = 0;
  endtask

  task automatic wr_sc(logic [1:0] s, logic d8, logic ws);
    @(negedge clk); sc_we = 1; sc_src = s; sc_div8 = d8; sc_wstop = ws;
    @(negedge clk); sc_we = 0;
  endtask

  task automatic wr_cd(logic [1:0] c, logic lo);
    @(negedge clk); cd_we = 1; cd_cpu = c; cd_lo_off = lo;
    @(negedge clk); cd_we = 0;
  endtask

  task automatic wr_hf(logic on, logic [2:0] c);
    @(negedge clk); hf_we = 1; hf_on = on; hf_code = c;
    @(negedge clk); hf_we = 0;
  endtask

  task automatic cpu_period(int which, output int n);
    n = 0;
    do begin tick(which); n++; end while (!cpu_en && n < 64);
  endtask

  task automatic hs_period(output int n);
    n = 0;
    do begin tick(3); n++; end while (!hsdiv_en && n < 64);
  endtask

  task automatic t_reset();
    int c = 0;
    @(negedge clk);
    check("R1 reset outputs", {cpu_en, f1_en, f2_en, f4_en, f8_en, f32_en, oco_en, hs_en, hsdiv_en, ls_en}, 0);
    rst_n = 1;
    for (int i = 0; i < 3; i++) begin tick(0); c += cpu_en; end
    for (int i = 0; i < 2; i++) begin tick(1); c += cpu_en; end
    check("R1 main/sub ignored after reset", c, 0);
    tick(2);
    check("R1 ls tick gives cpu_en", cpu_en, 1);
    @(negedge clk);
    check("R5 one cycle wide", cpu_en, 0);
  endtask

  task automatic t_ratios();
    int n;
    int exp_r[4] = '{1, 2, 4, 16};
    wr_sc(2'b00, 0, 0);
    tick(2);
    tick(0);
    check("R2 main selected after term count", cpu_en, 1);
    for (int c = 0; c < 4; c++) begin
      wr_cd(c[1:0], 0);
      cpu_period(0, n);
      cpu_period(0, n);
      check("R3 cpu ratio code", n, exp_r[c]);
    end
    wr_sc(2'b00, 1, 0);
    cpu_period(0, n);
    cpu_period(0, n);
    check("R3 div8 priority", n, 8);
    wr_sc(2'b00, 0, 0);
    cpu_period(0, n);
    cpu_period(0, n);
    check("R3 back to 16", n, 16);
    for (int i = 0; i < 3; i++) tick(0);
    wr_cd(2'b00, 0);
    cpu_period(0, n);
    check("R4 old period completes", n, 13);
    cpu_period(0, n);
    check("R4 new ratio after term", n, 1);
  endtask

  task automatic t_source();
    wr_sc(2'b01, 0, 0);
    tick(1);
    check("R2 sub ignored before term", cpu_en, 0);
    tick(0);
    check("R2 main term loads sub", cpu_en, 1);
    tick(0);
    check("R2 main ignored after switch", cpu_en, 0);
    tick(1);
    check("R2 sub drives cpu", cpu_en, 1);
  endtask

  task automatic t_taps();
    int c1 = 0, c2 = 0, c4 = 0, c8 = 0, c32 = 0, first32 = 0, q = 0;
    wr_hf(1, 3'd0);
    wr_sc(2'b01, 0, 1);
    @(negedge clk); wait_mode = 1;
    for (int i = 0; i < 5; i++) begin tick(1); q += f1_en + f2_en + f4_en + f8_en + f32_en; end
    check("R7 taps stopped in wait", q, 0);
    tick(2);
    check("R8 oco runs in wait", oco_en, 1);
    tick(3);
    check("R8 hs runs in wait", hs_en, 1);
    @(negedge clk); wait_mode = 0;
    for (int i = 1; i <= 64; i++) begin
      tick(1);
      c1 += f1_en; c2 += f2_en; c4 += f4_en; c8 += f8_en; c32 += f32_en;
      if (f32_en && first32 == 0) first32 = i;
    end
    check("R6 f1 count", c1, 64);
    check("R6 f2 count", c2, 32);
    check("R6 f4 count", c4, 16);
    check("R6 f8 count", c8, 8);
    check("R6 f32 count", c32, 2);
    check("R7 first f32 after release", first32, 32);
    wr_sc(2'b01, 0, 0);
    @(negedge clk); wait_mode = 1;
    q = 0;
    for (int i = 0; i < 4; i++) begin tick(1); q += f1_en; end
    check("R7 taps run when stop bit clear", q, 4);
    @(negedge clk); wait_mode = 0;
  endtask

  task automatic t_stop();
    int n;
    stop_nochg = 0;
    @(negedge clk); stop_entry = 1;
    @(negedge clk); stop_entry = 0;
    cpu_period(1, n);
    cpu_period(1, n);
    check("R9 stop forces div8", n, 8);
    wr_sc(2'b01, 0, 0);
    cpu_period(1, n);
    cpu_period(1, n);
    check("R9 ratio 1 restored", n, 1);
    stop_nochg = 1;
    @(negedge clk); stop_entry = 1;
    @(negedge clk); stop_entry = 0;
    cpu_period(1, n);
    cpu_period(1, n);
    check("R9 stop ignored when nochg", n, 1);
    stop_nochg = 0;
    @(negedge clk); stop_entry = 1; sc_we = 1; sc_src = 2'b01; sc_div8 = 0; sc_wstop = 0;
    @(negedge clk); stop_entry = 0; sc_we = 0;
    cpu_period(1, n);
    cpu_period(1, n);
    check("R9 stop beats write", n, 8);
    wr_sc(2'b01, 0, 0);
  endtask

  task automatic t_hs();
    int n, q = 0;
    for (int c = 0; c < 8; c++) begin
      wr_hf(0, c[2:0]);
      wr_hf(1, c[2:0]);
      hs_period(n);
      check("R10 hs divider first period", n, c + 2);
      hs_period(n);
      check("R10 hs divider period", n, c + 2);
    end
    wr_hf(0, 3'd2);
    for (int i = 0; i < 10; i++) begin tick(3); q += hsdiv_en + hs_en; end
    check("R11 hs outputs off when disabled", q, 0);
    wr_hf(1, 3'd2);
    tick(3);
    check("R11 hs follows tick", hs_en, 1);
  endtask

  task automatic t_ls();
    tick(2);
    check("R12 ls_en on", ls_en, 1);
    wr_cd(2'b00, 1);
    tick(2);
    check("R12 ls_en gated", ls_en, 0);
    check("R12 oco_en unaffected", oco_en, 1);
    wr_cd(2'b00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ratios();
    t_source();
    t_taps();
    t_stop();
    t_hs();
    t_ls();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1ms;
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule